// File: doc/BRIEF.md
# Button-to-LED Handshake Agent

This block takes the place of a small soft processor in a scheme where several agents share one LED port and a host arbitrates access to it. A rising edge on the push-button input starts a transaction. The agent sends a "button pressed" word to the host through an outgoing mailbox and waits for a grant acknowledgement on the incoming mailbox. It then writes the shared LED port once, reports that the LED value is set, and waits for a final acknowledgement before it returns to idle.

Every message is a 32-bit word that holds a four-character, null-terminated ASCII string. The agent's own processor digit is a parameter. Words addressed to other agents are drained and ignored. A negative or unexpected reply makes the agent resend its last word, up to a fixed number of times. After that it gives up and raises a one-cycle error pulse.

Top module: `hs_led_agent`

## Requirements
- R1: Every sent word carries the type character in bits 7:0, the processor digit ('0' plus PROC_ID) in bits 15:8, the data character '0' (0x30) in bits 23:16 and 0x00 in bits 31:24. The button message type is 'B' (0x42) and the LED-ready message type is 'L' (0x4C).
- R2: The button input passes through a two-stage synchronizer followed by rising-edge detection. In idle, a detected edge causes the 'B' word to be offered from the third clock edge after the input rises.
- R3: tx_valid_o is asserted only in a cycle where tx_empty_i is high. While tx_empty_i stays low, the pending word is held back. Each word is sent with a single one-cycle pulse.
- R4: rx_read_o is asserted only while the agent is waiting for a reply and rx_pending_i is high. rx_data_i is consumed in that same cycle.
- R5: An acknowledgement is the word 'A', own digit, 'A', 0x00 (0x00413?41 with the digit in bits 15:8). led_we_o pulses for exactly one cycle, in the cycle after the acknowledgement of the 'B' word is read, and at no other time.
- R6: The LED value is a LED_W-bit counter that starts at 0 after reset and increments on each granted press, so the first write is 1. It wraps modulo 2^LED_W, and led_o holds the last written value.
- R7: After the LED write, the 'L' word is sent. Once its acknowledgement is read, the agent returns to idle and accepts a new press.
- R8: A word whose bits 15:8 differ from the own digit is read and discarded, and the agent keeps waiting with no other effect.
- R9: A NACK ('N' type) or any other non-ACK word carrying the own digit makes the agent resend the word it last sent.
- R10: When a fourth non-ACK reply arrives after three resends of the same word, the agent returns to idle and err_o pulses for one cycle. No LED write takes place.
- R11: Button edges that occur while a transaction is in progress are ignored.
- R12: In reset, led_o is 0 and tx_valid_o, rx_read_o, led_we_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| button_i | input | 1 | Raw push-button level |
| led_o | output | LED_W | Last value written to the shared LED port |
| led_we_o | output | 1 | One-cycle LED write strobe |
| tx_data_o | output | 32 | Outgoing message word |
| tx_valid_o | output | 1 | Pushes tx_data_o into the outgoing mailbox |
| tx_empty_i | input | 1 | Outgoing mailbox reports empty |
| rx_data_i | input | 32 | Head word of the incoming mailbox |
| rx_pending_i | input | 1 | Incoming mailbox holds a word |
| rx_read_o | output | 1 | Pops the incoming word this cycle |
| err_o | output | 1 | One-cycle pulse when retries are exhausted |

## Verification
The agent is exercised with clean grant-and-confirm exchanges, which establish the word encodings and the LED count. The outgoing mailbox is held full to show that sending waits on the empty flag. A reply addressed to a different digit is injected to separate discard from retry. A NACK in each wait phase shows that the matching word is resent, and four NACKs in a row drive the agent into the give-up path. Extra button presses during a transaction check that they are ignored, and a long run of grants carries the LED count through its wrap.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned MSG_W = 32;

  localparam logic [7:0] CH_BTN  = 8'h42;
  localparam logic [7:0] CH_LED  = 8'h4C;
  localparam logic [7:0] CH_ACK  = 8'h41;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_NUL  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_BTN,
    ST_WAIT_GRANT,
    ST_LED_WR,
    ST_TX_RDY,
    ST_WAIT_DONE
  } hs_state_e;

  // byte 0 in the low bits: little-endian string order
  function automatic logic [MSG_W-1:0] pack_msg(logic [7:0] kind, logic [7:0] proc,
                                                logic [7:0] data);
    return {CH_NUL, data, proc, kind};
  endfunction
endpackage

// File: rtl/hs_btn_edge.sv
module hs_btn_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic rise_o
);
  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[PIPE_W-2:0], btn_i};
  end

  assign rise_o = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

  assert_rise_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hs_msg_check.sv
module hs_msg_check
  import hs_pkg::*;
#(
  parameter int unsigned PROC_ID = 0
) (
  input  logic [MSG_W-1:0] word_i,
  output logic             mine_o,
  output logic             ack_o
);
  localparam logic [7:0] ID_CHAR = 8'(CH_ZERO + PROC_ID);

  logic [7:0] kind, proc, data, term;

  assign {term, data, proc, kind} = word_i;
  assign mine_o = (proc == ID_CHAR);
  assign ack_o  = (kind == CH_ACK) && (data == CH_ACK) && (term == CH_NUL);
endmodule

// File: rtl/hs_retry_ctr.sv
module hs_retry_ctr #(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int unsigned CNT_W = $clog2(MAX_RETRY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q == CNT_W'(MAX_RETRY));

  assert_retry_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> !spent_o);
endmodule

// File: rtl/hs_led_agent.sv
module hs_led_agent
  import hs_pkg::*;
#(
  parameter int unsigned PROC_ID     = 0,
  parameter int unsigned LED_W       = 4,
  parameter int unsigned MAX_RETRY   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             button_i,
  output logic [LED_W-1:0] led_o,
  output logic             led_we_o,
  output logic [31:0]      tx_data_o,
  output logic             tx_valid_o,
  input  logic             tx_empty_i,
  input  logic [31:0]      rx_data_i,
  input  logic             rx_pending_i,
  output logic             rx_read_o,
  output logic             err_o
);
  localparam logic [7:0] ID_CHAR = 8'(CH_ZERO + PROC_ID);

  hs_state_e        state_q, state_d;
  logic [LED_W-1:0] led_q;
  logic             err_q;
  logic             rise, mine, is_ack, spent;
  logic             hit_ack, hit_other, waiting, sending;

  hs_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .btn_i (button_i),
    .rise_o(rise)
  );

  hs_msg_check #(.PROC_ID(PROC_ID)) u_chk (
    .word_i(rx_data_i),
    .mine_o(mine),
    .ack_o (is_ack)
  );

  assign waiting   = (state_q == ST_WAIT_GRANT) || (state_q == ST_WAIT_DONE);
  assign sending   = (state_q == ST_TX_BTN) || (state_q == ST_TX_RDY);
  assign rx_read_o = waiting && rx_pending_i;
  assign hit_ack   = rx_read_o && mine && is_ack;
  assign hit_other = rx_read_o && mine && !is_ack;

  hs_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((state_q == ST_IDLE) || hit_ack),
    .inc_i  (hit_other && !spent),
    .spent_o(spent)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (rise) state_d = ST_TX_BTN;
      ST_TX_BTN:     if (tx_empty_i) state_d = ST_WAIT_GRANT;
      ST_WAIT_GRANT: begin
        if (hit_ack)        state_d = ST_LED_WR;
        else if (hit_other) state_d = spent ? ST_IDLE : ST_TX_BTN;
      end
      ST_LED_WR:     state_d = ST_TX_RDY;
      ST_TX_RDY:     if (tx_empty_i) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (hit_ack)        state_d = ST_IDLE;
        else if (hit_other) state_d = spent ? ST_IDLE : ST_TX_RDY;
      end
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      led_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= hit_other && spent;
      if (state_q == ST_WAIT_GRANT && hit_ack) led_q <= led_q + 1'b1;
    end
  end

  assign tx_valid_o = sending && tx_empty_i;
  assign tx_data_o  = pack_msg((state_q == ST_TX_RDY) ? CH_LED : CH_BTN, ID_CHAR, CH_ZERO);
  assign led_we_o   = (state_q == ST_LED_WR);
  assign led_o      = led_q;
  assign err_o      = err_q;

  assert_tx_needs_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_empty_i);
  assert_tx_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);
  assert_tx_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o[31:24] == 8'h00 && tx_data_o[15:8] == ID_CHAR
                    && tx_data_o[23:16] == CH_ZERO));
  assert_rx_needs_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_read_o |-> rx_pending_i);
  assert_led_after_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_we_o |-> $past(rx_read_o));
  assert_led_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_we_o |-> (led_o == LED_W'($past(led_o) + 1'b1)));
  assert_led_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !led_we_o |=> (led_we_o || $stable(led_o)));
  assert_err_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_one_action_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_valid_o, rx_read_o, led_we_o}));
endmodule

// File: tb/hs_led_agent_tb_top.sv
module hs_led_agent_tb_top;
  localparam int unsigned ID    = 3;
  localparam int unsigned LED_W = 4;
  localparam logic [7:0]  IDC   = 8'(8'h30 + ID);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             btn = 1'b0;
  logic [LED_W-1:0] led_o;
  logic             led_we_o, tx_valid_o, rx_read_o, err_o;
  logic [31:0]      tx_data_o;
  logic             tx_empty = 1'b1;
  logic [31:0]      rx_data = '0;
  logic             rx_pending = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int tx_cnt = 0, we_cnt = 0, err_cnt = 0;
  logic [31:0]      last_tx = '0;
  logic [LED_W-1:0] last_led = '0;

  always #5 clk = ~clk;

  hs_led_agent #(.PROC_ID(ID), .LED_W(LED_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .button_i(btn),
    .led_o(led_o), .led_we_o(led_we_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_empty_i(tx_empty),
    .rx_data_i(rx_data), .rx_pending_i(rx_pending), .rx_read_o(rx_read_o),
    .err_o(err_o)
  );

  function automatic logic [31:0] msg(logic [7:0] k, logic [7:0] p, logic [7:0] d);
    return {8'h00, d, p, k};
  endfunction

  localparam logic [31:0] W_B   = {8'h00, 8'h30, IDC, 8'h42};
  localparam logic [31:0] W_L   = {8'h00, 8'h30, IDC, 8'h4C};
  localparam logic [31:0] W_ACK = {8'h00, 8'h41, IDC, 8'h41};
  localparam logic [31:0] W_NAK = {8'h00, 8'h4E, IDC, 8'h4E};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 offer B, 2 await grant, 3 LED write,
  // 4 offer L, 5 await final ack
  int               m_phase = 0, m_tries = 0;
  logic [2:0]       m_sync = '0;
  logic [LED_W-1:0] m_led = '0;
  logic             m_err = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_tries = 0; m_sync = '0; m_led = '0; m_err = 1'b0;
    end else begin
      automatic bit edge_seen = m_sync[1] && !m_sync[2];
      automatic bit mine = rx_data[15:8] == IDC;
      automatic bit ack  = rx_data[7:0] == 8'h41 && rx_data[23:16] == 8'h41
                           && rx_data[31:24] == 8'h00;
      m_err = 1'b0;
      m_sync = {m_sync[1:0], btn};
      case (m_phase)
        0: if (edge_seen) begin m_phase = 1; m_tries = 0; end
        1: if (tx_empty) m_phase = 2;
        3: m_phase = 4;
        4: if (tx_empty) m_phase = 5;
        2, 5: if (rx_pending && mine) begin
          if (ack) begin
            if (m_phase == 2) begin m_led = m_led + 1'b1; m_phase = 3; end
            else m_phase = 0;
            m_tries = 0;
          end else if (m_tries == 3) begin
            m_phase = 0; m_err = 1'b1;
          end else begin
            m_tries++; m_phase = m_phase - 1;
          end
        end
        default: m_phase = 0;
      endcase
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      automatic bit       e_tx = (m_phase == 1 || m_phase == 4) && tx_empty;
      automatic bit       e_rd = (m_phase == 2 || m_phase == 5) && rx_pending;
      automatic logic [31:0] e_w = (m_phase == 4) ? W_L : W_B;
      check("R3 tx_valid", 32'(tx_valid_o), 32'(e_tx));
      if (e_tx) check("R1 tx_data", tx_data_o, e_w);
      check("R4 rx_read", 32'(rx_read_o), 32'(e_rd));
      check("R5 led_we", 32'(led_we_o), 32'(m_phase == 3));
      check("R6 led", 32'(led_o), 32'(m_led));
      check("R10 err", 32'(err_o), 32'(m_err));
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (tx_valid_o) begin tx_cnt++; last_tx = tx_data_o; end
      if (led_we_o) begin we_cnt++; last_led = led_o; end
      if (err_o) err_cnt++;
    end
  end

  task automatic press();
    @(negedge clk); btn = 1'b1;
    @(negedge clk); btn = 1'b0;
  endtask

  task automatic get_tx(output logic [31:0] w);
    forever begin
      #1;
      if (tx_valid_o) begin w = tx_data_o; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_rx(logic [31:0] w);
    @(negedge clk); rx_pending = 1'b1; rx_data = w;
    forever begin
      #1;
      if (rx_read_o) break;
      @(negedge clk);
    end
    @(posedge clk); #1; rx_pending = 1'b0;
  endtask

  task automatic full_txn();
    logic [31:0] w;
    press();
    get_tx(w); check("R2 B word", w, W_B);
    send_rx(W_ACK);
    get_tx(w); check("R7 L word", w, W_L);
    send_rx(W_ACK);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] w;
    int snap;
    repeat (3) @(negedge clk);
    #3;
    check("R12 led reset", 32'(led_o), 0);
    check("R12 strobes reset", {28'd0, tx_valid_o, rx_read_o, led_we_o, err_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R5 R6 R7: clean exchange
    press();
    get_tx(w); check("R1 B word", w, W_B);
    send_rx(W_ACK);
    @(negedge clk); #3;
    check("R5 write count", we_cnt, 1);
    check("R6 first value", 32'(last_led), 1);
    get_tx(w); check("R7 L word", w, W_L);
    send_rx(W_ACK);
    repeat (3) @(negedge clk);

    // R3: outgoing queue held full
    tx_empty = 1'b0; snap = tx_cnt;
    press();
    repeat (10) @(negedge clk);
    check("R3 held while full", tx_cnt, snap);
    tx_empty = 1'b1;
    get_tx(w); check("R3 B after empty", w, W_B);
    send_rx(W_ACK);
    get_tx(w); send_rx(W_ACK);
    repeat (3) @(negedge clk);
    check("R6 second value", 32'(last_led), 2);

    // R8: reply for another processor digit
    press();
    get_tx(w);
    snap = we_cnt;
    send_rx(msg(8'h41, 8'h35, 8'h41));
    repeat (5) @(negedge clk);
    check("R8 foreign ack no write", we_cnt, snap);
    check("R8 led unchanged", 32'(led_o), 2);
    send_rx(W_ACK);
    get_tx(w); check("R8 then L", w, W_L);
    send_rx(W_ACK);
    repeat (3) @(negedge clk);

    // R9: NACK to B, then non-ACK to L
    press();
    get_tx(w);
    send_rx(W_NAK);
    get_tx(w); check("R9 B resent", w, W_B);
    send_rx(W_ACK);
    get_tx(w);
    send_rx(msg(8'h42, IDC, 8'h30));
    get_tx(w); check("R9 L resent", w, W_L);
    send_rx(W_ACK);
    repeat (3) @(negedge clk);
    check("R9 led after retries", 32'(last_led), 4);

    // R10: retries exhausted
    press();
    get_tx(w);
    snap = we_cnt;
    for (int i = 0; i < 3; i++) begin
      send_rx(W_NAK);
      get_tx(w); check("R10 resend", w, W_B);
    end
    send_rx(W_NAK);
    repeat (4) @(negedge clk);
    check("R10 error pulse", err_cnt, 1);
    check("R10 no LED write", we_cnt, snap);
    check("R10 led held", 32'(led_o), 4);

    // R11: presses during a transaction
    press();
    get_tx(w);
    press();
    send_rx(W_ACK);
    get_tx(w);
    press();
    send_rx(W_ACK);
    snap = tx_cnt;
    repeat (20) @(negedge clk);
    check("R11 no extra B", tx_cnt, snap);
    check("R11 led", 32'(last_led), 5);

    // R6: wrap after 16 grants
    for (int i = 0; i < 11; i++) full_txn();
    check("R6 wrap", 32'(last_led), 0);
    check("R7 writes total", we_cnt, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule